// File: doc/BRIEF.md
# Load/Store Unit for an 8-bit Harvard Core

This unit carries out memory micro-operations for a small 8-bit core whose instructions live in a separate, 16-bit-wide program memory. The core hands it one request at a time. Each request carries an operation, a pointer choice, an addressing mode, a 6-bit displacement, a working-register number and an I/O number. The unit performs five operations:

- data-space load;
- data-space store;
- program-memory byte read;
- direct I/O read into a register;
- direct I/O write from a register.

The unit owns the 32 working registers, the 64 I/O registers and the data SRAM. All three are reached through one flat data address map.

Indirect accesses build their address from one of three 16-bit pointers held in pairs of working registers. The pointer may be used unchanged, post-incremented, pre-decremented or offset by the displacement. The modified pointer is written back when the access finishes.

Each class of access has its own fixed latency. The core sees `busy` for that many cycles, then a one-cycle `done` together with the loaded byte and the pointer update.

Top module: `harv_lsu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done` and `ptr_wr_en` are 0, and `load_data` and `eff_addr` read 0.
- R2: Data addresses map to storage as follows:
  - 0x0000 to 0x001F select working register n = address.
  - 0x0020 to 0x005F select I/O register (address - 0x20).
  - 0x0060 to 0x0060+SRAM_DEPTH-1 select SRAM byte (address - 0x60).
- R3: A data address above the SRAM range maps to nothing. A store to it changes no storage, and a load from it returns 0x00.
- R4: The address modes (`req_mode`) form the effective address from pointer p as follows:
  - 0 (plain): p.
  - 1 (post-increment): p.
  - 2 (pre-decrement): p-1.
  - 3 (displacement): p plus the zero-extended `req_disp`.
  - `eff_addr` shows this address while `busy` is high.
- R5: Pointers are selected by `req_ptr`: 0 for X = R27:R26, 1 for Y = R29:R28, 2 for Z = R31:R30, with the high byte in the odd register. Post-increment writes back p+1 and pre-decrement writes back p-1. In the `done` cycle, `ptr_wr_en` is 1 and `ptr_wr_sel`/`ptr_wr_val` show the pair and its new value. The other modes leave the pointer alone and keep `ptr_wr_en` at 0.
- R6: Operations are encoded in `req_op`: 0 load, 1 store, 2 program-memory read, 3 I/O read, 4 I/O write. A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. After acceptance, `busy` is 1 for exactly 2 cycles (load or store), 3 cycles (program read) or 1 cycle (I/O read or write). `done` is then 1 for a single cycle, during which `busy` is 0.
- R7: A request presented while `busy` is 1 is ignored. It does not change the access in progress, its latency, `eff_addr`, or any storage.
- R8: A program-memory read always uses Z. It reads word Z[8:1] and returns the low byte when Z[0]=0 and the high byte when Z[0]=1. Post-increment mode advances Z by one; the other modes leave Z unchanged. Word w holds:
  - low byte: w XOR 0x96;
  - high byte: (w with its nibbles swapped) + 0x21 (mod 256).
- R9: The direct I/O operations move a byte between working register `req_reg` and I/O register `req_io`. They never update a pointer, and `eff_addr` shows 0x20 + `req_io`.
- R10: Loads, program reads and I/O reads write the byte into working register `req_reg` and present it on `load_data` in the `done` cycle. When that register is also a byte of the pointer being written back, the loaded byte wins.
- R11: Reset sets working register n to (37*n + 5) mod 256, except R27, R29 and R31, which reset to 0. X, Y and Z therefore start at 0x00C7, 0x0011 and 0x005B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_ptr | input | 2 | Pointer choice (X, Y, Z) |
| req_mode | input | 2 | Addressing mode |
| req_disp | input | DISP_W | Displacement for mode 3 |
| req_reg | input | 5 | Working register used as source or target |
| req_io | input | 6 | I/O register number for direct I/O operations |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| eff_addr | output | 16 | Effective address of the current or last access |
| load_data | output | 8 | Byte delivered by the last loading operation |
| ptr_wr_en | output | 1 | Pointer written back with this completion |
| ptr_wr_sel | output | 2 | Pointer pair written back |
| ptr_wr_val | output | 16 | New pointer value |

## Verification
A wrong address mode or pointer-pair selection shows up on `eff_addr` in the first busy cycle, and on `ptr_wr_val` at `done`. A stray write, or a wrong region decode, corrupts storage silently. It surfaces only when a later load reads the byte that was affected, so the bench follows every store with reads that can reach it. A miscounted latency is visible directly in how long `busy` stays high. A lost priority between the loaded byte and the pointer write-back shows up when the pair is next used as an address.

// File: rtl/harv_lsu_pkg.sv
`timescale 1ns/1ps
package harv_lsu_pkg;

  localparam int          NREG      = 32;
  localparam int          NIO       = 64;
  localparam logic [15:0] IO_BASE   = 16'h0020;
  localparam logic [15:0] SRAM_BASE = 16'h0060;

  typedef enum logic [2:0] {
    OP_LD  = 3'd0,
    OP_ST  = 3'd1,
    OP_LPM = 3'd2,
    OP_IN  = 3'd3,
    OP_OUT = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SP_REG  = 2'd0,
    SP_IO   = 2'd1,
    SP_SRAM = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  function automatic logic [1:0] op_latency(op_e op);
    case (op)
      OP_LD, OP_ST: return 2'd2;
      OP_LPM:       return 2'd3;
      default:      return 2'd1;
    endcase
  endfunction

  function automatic logic op_loads(op_e op);
    return (op == OP_LD) || (op == OP_LPM) || (op == OP_IN);
  endfunction

  function automatic logic [15:0] mode_addr(logic [15:0] p, mode_e m, logic [15:0] d);
    case (m)
      AM_PREDEC: return p - 16'd1;
      AM_DISP:   return p + d;
      default:   return p;
    endcase
  endfunction

  function automatic logic [15:0] mode_next(logic [15:0] p, mode_e m);
    case (m)
      AM_POSTINC: return p + 16'd1;
      AM_PREDEC:  return p - 16'd1;
      default:    return p;
    endcase
  endfunction

  function automatic logic mode_updates(mode_e m);
    return (m == AM_POSTINC) || (m == AM_PREDEC);
  endfunction

  // constant program word: index folded to 8 bits, then scrambled
  function automatic logic [15:0] pm_word(logic [15:0] widx);
    logic [7:0] f;
    f = widx[7:0] ^ widx[15:8];
    return {({f[3:0], f[7:4]} + 8'h21), (f ^ 8'h96)};
  endfunction

  function automatic logic [7:0] reg_reset(int n);
    if (n == 27 || n == 29 || n == 31) return 8'h00;
    return 8'(n * 37 + 5);
  endfunction

endpackage

// File: rtl/lsu_agen.sv
`timescale 1ns/1ps
module lsu_agen
  import harv_lsu_pkg::*;
#(
  parameter int DISP_W = 6
) (
  input  logic [2:0][15:0]   ptrs,
  input  logic [1:0]         sel,
  input  mode_e              mode,
  input  logic [DISP_W-1:0]  disp,
  input  op_e                op,
  input  logic [5:0]         io_num,
  output logic [15:0]        addr,
  output logic [15:0]        nxt,
  output logic               upd,
  output logic [1:0]         upd_sel
);

  logic [1:0]  psel;
  logic [15:0] p;
  logic [15:0] dext;

  assign dext = {{(16-DISP_W){1'b0}}, disp};

  always_comb begin
    psel = (op == OP_LPM || sel == 2'd3) ? 2'd2 : sel;
    case (psel)
      2'd0:    p = ptrs[0];
      2'd1:    p = ptrs[1];
      default: p = ptrs[2];
    endcase
  end

  always_comb begin
    upd_sel = psel;
    nxt     = p;
    upd     = 1'b0;
    case (op)
      OP_LD, OP_ST: begin
        addr = mode_addr(p, mode, dext);
        nxt  = mode_next(p, mode);
        upd  = mode_updates(mode);
      end
      OP_LPM: begin
        addr = p;
        upd  = (mode == AM_POSTINC);
        nxt  = p + 16'd1;
      end
      default: begin
        addr = IO_BASE + {10'b0, io_num};
      end
    endcase
  end

endmodule

// File: rtl/lsu_region.sv
`timescale 1ns/1ps
module lsu_region
  import harv_lsu_pkg::*;
#(
  parameter int SRAM_DEPTH = 256
) (
  input  logic [15:0] addr,
  output space_e      space,
  output logic [15:0] idx
);

  localparam logic [16:0] SRAM_END = 17'(SRAM_BASE) + 17'(SRAM_DEPTH);

  always_comb begin
    if (addr < IO_BASE) begin
      space = SP_REG;
      idx   = addr;
    end else if (addr < SRAM_BASE) begin
      space = SP_IO;
      idx   = addr - IO_BASE;
    end else if ({1'b0, addr} < SRAM_END) begin
      space = SP_SRAM;
      idx   = addr - SRAM_BASE;
    end else begin
      space = SP_NONE;
      idx   = 16'd0;
    end
  end

endmodule

// File: rtl/lsu_store.sv
`timescale 1ns/1ps
module lsu_store
  import harv_lsu_pkg::*;
#(
  parameter int SRAM_DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [2:0][15:0] ptr_o,
  input  space_e           rd_space,
  input  logic [15:0]      rd_idx,
  output logic [7:0]       rd_data,
  input  logic [4:0]       src_idx,
  output logic [7:0]       src_data,
  input  logic             pw_en,
  input  logic [1:0]       pw_sel,
  input  logic [15:0]      pw_val,
  input  logic             dw_en,
  input  space_e           dw_space,
  input  logic [15:0]      dw_idx,
  input  logic [7:0]       dw_data
);

  localparam int SW = (SRAM_DEPTH > 1) ? $clog2(SRAM_DEPTH) : 1;

  logic [7:0] rf   [NREG];
  logic [7:0] io_q [NIO];
  logic [7:0] sram [SRAM_DEPTH];
  logic       unused_idx;

  assign unused_idx = ^{rd_idx, dw_idx};

  for (genvar g = 0; g < 3; g++) begin : g_ptr
    assign ptr_o[g] = {rf[27 + 2*g], rf[26 + 2*g]};
  end

  always_comb begin
    case (rd_space)
      SP_REG:  rd_data = rf[rd_idx[4:0]];
      SP_IO:   rd_data = io_q[rd_idx[5:0]];
      SP_SRAM: rd_data = sram[rd_idx[SW-1:0]];
      default: rd_data = 8'h00;
    endcase
  end

  assign src_data = rf[src_idx];

  // working registers: pointer write-back first, data write overrides
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= reg_reset(i);
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (pw_en && (i == 26 + 2*int'(pw_sel))) rf[i] <= pw_val[7:0];
        if (pw_en && (i == 27 + 2*int'(pw_sel))) rf[i] <= pw_val[15:8];
        if (dw_en && dw_space == SP_REG && 5'(i) == dw_idx[4:0]) rf[i] <= dw_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIO; i++) io_q[i] <= 8'h00;
    end else if (dw_en && dw_space == SP_IO) begin
      io_q[dw_idx[5:0]] <= dw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SRAM_DEPTH; i++) sram[i] <= 8'h00;
    end else if (dw_en && dw_space == SP_SRAM) begin
      sram[dw_idx[SW-1:0]] <= dw_data;
    end
  end

  // R3
  no_unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw_en |-> dw_space != SP_NONE);

endmodule

// File: rtl/lsu_ctrl.sv
`timescale 1ns/1ps
module lsu_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] lat,
  output logic       accept,
  output logic       busy,
  output logic       fin
);

  logic [1:0] cnt;

  assign busy   = (cnt != 2'd0);
  assign fin    = (cnt == 2'd1);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= 2'd0;
    else if (accept) cnt <= lat;
    else if (busy)   cnt <= cnt - 2'd1;
  end

  // R6
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fin) |=> busy);

  // R6
  fin_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy);

endmodule

// File: rtl/harv_lsu.sv
`timescale 1ns/1ps
module harv_lsu
  import harv_lsu_pkg::*;
#(
  parameter int SRAM_DEPTH = 256,
  parameter int DISP_W     = 6,
  parameter int PM_AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_ptr,
  input  logic [1:0]        req_mode,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [4:0]        req_reg,
  input  logic [5:0]        req_io,
  output logic              busy,
  output logic              done,
  output logic [15:0]       eff_addr,
  output logic [7:0]        load_data,
  output logic              ptr_wr_en,
  output logic [1:0]        ptr_wr_sel,
  output logic [15:0]       ptr_wr_val
);

  op_e   in_op;
  mode_e in_mode;
  assign in_op   = op_e'(req_op);
  assign in_mode = mode_e'(req_mode);

  // ---- control ----
  logic accept, fin;

  lsu_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .lat       (op_latency(in_op)),
    .accept    (accept),
    .busy      (busy),
    .fin       (fin)
  );

  // ---- address generation ----
  logic [2:0][15:0] ptrs;
  logic [15:0]      a_addr, a_nxt;
  logic             a_upd;
  logic [1:0]       a_sel;

  lsu_agen #(.DISP_W(DISP_W)) u_agen (
    .ptrs    (ptrs),
    .sel     (req_ptr),
    .mode    (in_mode),
    .disp    (req_disp),
    .op      (in_op),
    .io_num  (req_io),
    .addr    (a_addr),
    .nxt     (a_nxt),
    .upd     (a_upd),
    .upd_sel (a_sel)
  );

  // ---- request capture ----
  op_e         c_op;
  logic [4:0]  c_reg;
  logic [5:0]  c_io;
  logic [15:0] c_addr, c_nxt;
  logic        c_upd;
  logic [1:0]  c_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_op   <= OP_LD;
      c_reg  <= 5'd0;
      c_io   <= 6'd0;
      c_addr <= 16'd0;
      c_nxt  <= 16'd0;
      c_upd  <= 1'b0;
      c_sel  <= 2'd0;
    end else if (accept) begin
      c_op   <= in_op;
      c_reg  <= req_reg;
      c_io   <= req_io;
      c_addr <= a_addr;
      c_nxt  <= a_nxt;
      c_upd  <= a_upd;
      c_sel  <= a_sel;
    end
  end

  assign eff_addr = c_addr;

  // ---- region decode ----
  space_e      rg_space;
  logic [15:0] rg_idx;

  lsu_region #(.SRAM_DEPTH(SRAM_DEPTH)) u_region (
    .addr  (c_addr),
    .space (rg_space),
    .idx   (rg_idx)
  );

  // ---- final-cycle steering ----
  space_e      rd_space, dw_space;
  logic [15:0] rd_idx, dw_idx;
  logic [7:0]  rd_data, src_data, dw_data, ld_byte, pm_byte;
  logic [15:0] pm_w;
  logic        dw_en, pw_en;

  assign pm_w    = pm_word(16'(c_addr[PM_AW:1]));
  assign pm_byte = c_addr[0] ? pm_w[15:8] : pm_w[7:0];
  assign pw_en   = fin && c_upd;

  always_comb begin
    rd_space = SP_NONE;
    rd_idx   = 16'd0;
    case (c_op)
      OP_LD: begin rd_space = rg_space; rd_idx = rg_idx; end
      OP_IN: begin rd_space = SP_IO;    rd_idx = {10'b0, c_io}; end
      default: ;
    endcase
  end

  always_comb begin
    case (c_op)
      OP_LD:   ld_byte = (rg_space == SP_NONE) ? 8'h00 : rd_data;
      OP_IN:   ld_byte = rd_data;
      OP_LPM:  ld_byte = pm_byte;
      default: ld_byte = 8'h00;
    endcase
  end

  always_comb begin
    dw_en    = 1'b0;
    dw_space = SP_NONE;
    dw_idx   = 16'd0;
    dw_data  = 8'h00;
    if (fin) begin
      case (c_op)
        OP_LD, OP_IN, OP_LPM: begin
          dw_en = 1'b1; dw_space = SP_REG; dw_idx = {11'b0, c_reg}; dw_data = ld_byte;
        end
        OP_ST: begin
          dw_en = (rg_space != SP_NONE); dw_space = rg_space; dw_idx = rg_idx; dw_data = src_data;
        end
        OP_OUT: begin
          dw_en = 1'b1; dw_space = SP_IO; dw_idx = {10'b0, c_io}; dw_data = src_data;
        end
        default: ;
      endcase
    end
  end

  lsu_store #(.SRAM_DEPTH(SRAM_DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_o    (ptrs),
    .rd_space (rd_space),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .src_idx  (c_reg),
    .src_data (src_data),
    .pw_en    (pw_en),
    .pw_sel   (c_sel),
    .pw_val   (c_nxt),
    .dw_en    (dw_en),
    .dw_space (dw_space),
    .dw_idx   (dw_idx),
    .dw_data  (dw_data)
  );

  // ---- completion outputs ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      load_data  <= 8'h00;
      ptr_wr_en  <= 1'b0;
      ptr_wr_sel <= 2'd0;
      ptr_wr_val <= 16'd0;
    end else begin
      done      <= fin;
      ptr_wr_en <= pw_en;
      if (pw_en) begin
        ptr_wr_sel <= c_sel;
        ptr_wr_val <= c_nxt;
      end
      if (fin && op_loads(c_op)) load_data <= ld_byte;
    end
  end

  // R7
  eff_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(eff_addr));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R5
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_en |-> (done && !busy));

  // R9
  io_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && (c_op == OP_IN || c_op == OP_OUT)) |=> !ptr_wr_en);

endmodule

// File: tb/test_harv_lsu.sv
`timescale 1ns/1ps
module test_harv_lsu;

  localparam int SRAM_D = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [1:0]  req_ptr = 2'd0;
  logic [1:0]  req_mode = 2'd0;
  logic [5:0]  req_disp = 6'd0;
  logic [4:0]  req_reg = 5'd0;
  logic [5:0]  req_io = 6'd0;
  logic        busy, done, ptr_wr_en;
  logic [15:0] eff_addr, ptr_wr_val;
  logic [7:0]  load_data;
  logic [1:0]  ptr_wr_sel;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] m_rf [32];
  logic [7:0] m_io [64];
  logic [7:0] m_sr [SRAM_D];

  harv_lsu i_harv_lsu (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ptr(req_ptr), .req_mode(req_mode), .req_disp(req_disp),
    .req_reg(req_reg), .req_io(req_io), .busy(busy), .done(done),
    .eff_addr(eff_addr), .load_data(load_data), .ptr_wr_en(ptr_wr_en),
    .ptr_wr_sel(ptr_wr_sel), .ptr_wr_val(ptr_wr_val)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rst_val(int n);
    int v;
    if (n % 2 == 1 && n >= 27) return 8'h00;
    v = (5 + n * 37) % 256;
    return 8'(v);
  endfunction

  // 0 reg, 1 io, 2 sram, 3 none
  function automatic int where(logic [15:0] a);
    if (a <= 16'h001F) return 0;
    if (a <= 16'h005F) return 1;
    if (int'(a) < 96 + SRAM_D) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] mem_rd(logic [15:0] a);
    case (where(a))
      0: return m_rf[a[4:0]];
      1: return m_io[int'(a) - 32];
      2: return m_sr[int'(a) - 96];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] prog_byte(logic [15:0] z);
    int w, hi, lo;
    w  = (int'(z) >> 1) & 255;
    lo = w ^ 'h96;
    hi = ((((w & 15) << 4) | (w >> 4)) + 'h21) & 255;
    return z[0] ? 8'(hi) : 8'(lo);
  endfunction

  task automatic do_op(input int op, input int sel, input int mode, input int disp,
                       input int r, input int iox, input string tag, input bit intrude);
    logic [15:0] p, a, nx;
    logic [7:0]  lv, sv;
    bit upd, loads;
    int lat, ps, lo_i, n;
    ps   = (op == 2) ? 2 : sel;
    lo_i = 26 + 2 * ps;
    p    = {m_rf[lo_i + 1], m_rf[lo_i]};
    nx = p; upd = 0; lv = 8'h00; a = p;
    case (op)
      0, 1: begin
        lat = 2;
        if (mode == 1) begin nx = p + 16'd1; upd = 1; end
        else if (mode == 2) begin nx = p - 16'd1; a = nx; upd = 1; end
        else if (mode == 3) a = p + 16'(disp);
      end
      2: begin
        lat = 3;
        if (mode == 1) begin nx = p + 16'd1; upd = 1; end
      end
      default: begin lat = 1; a = 16'(32 + iox); end
    endcase
    loads = (op == 0) || (op == 2) || (op == 3);
    if (op == 0) lv = mem_rd(a);
    if (op == 2) lv = prog_byte(p);
    if (op == 3) lv = m_io[iox];
    sv = m_rf[r];

    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_ptr = 2'(sel); req_mode = 2'(mode);
    req_disp = 6'(disp); req_reg = 5'(r); req_io = 6'(iox);
    @(negedge clk);
    if (intrude) begin
      req_op = 3'd1; req_ptr = 2'(($urandom % 3)); req_mode = 2'd3;
      req_disp = 6'($urandom); req_reg = 5'($urandom); req_io = 6'($urandom);
    end else req_valid = 1'b0;
    chk(busy === 1'b1, tag, "busy after accept", int'(busy), 1);
    chk(eff_addr === a, (op >= 3) ? "R9" : "R4", "eff_addr", int'(eff_addr), int'(a));
    n = 0;
    while (busy === 1'b1 && n < 8) begin
      n++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (intrude) chk(eff_addr === a, "R7", "eff_addr after ignored request", int'(eff_addr), int'(a));
    chk(n == lat, "R6", "busy cycles", n, lat);
    chk(done === 1'b1, "R6", "done pulse", int'(done), 1);
    if (loads) chk(load_data === lv, tag, "load_data", int'(load_data), int'(lv));
    chk(ptr_wr_en === upd, "R5", "ptr_wr_en", int'(ptr_wr_en), int'(upd));
    if (upd) begin
      chk(ptr_wr_val === nx, "R5", "ptr_wr_val", int'(ptr_wr_val), int'(nx));
      chk(ptr_wr_sel === 2'(ps), "R5", "ptr_wr_sel", int'(ptr_wr_sel), ps);
    end
    // model: pointer first, then data write
    if (upd) begin m_rf[lo_i] = nx[7:0]; m_rf[lo_i + 1] = nx[15:8]; end
    case (op)
      0, 2, 3: m_rf[r] = lv;
      1: case (where(a))
           0: m_rf[a[4:0]] = sv;
           1: m_io[int'(a) - 32] = sv;
           2: m_sr[int'(a) - 96] = sv;
           default: ;
         endcase
      4: m_io[iox] = sv;
      default: ;
    endcase
  endtask

  // read a working register out through an I/O slot
  task automatic peek_reg(input int r, input logic [7:0] exp, input string tag);
    do_op(4, 0, 0, 0, r, 63, tag, 0);
    do_op(3, 0, 0, 0, r, 63, tag, 0);
    chk(load_data === exp, tag, "register readback", int'(load_data), int'(exp));
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) m_rf[i] = rst_val(i);
    for (int i = 0; i < 64; i++) m_io[i] = 8'h00;
    for (int i = 0; i < SRAM_D; i++) m_sr[i] = 8'h00;

    repeat (3) @(negedge clk);
    // R1
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", int'({busy, done}), 0);
    chk(ptr_wr_en === 1'b0 && load_data === 8'h00, "R1", "wb/load in reset", int'(load_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(eff_addr === 16'h0000 && busy === 1'b0, "R1", "after reset", int'(eff_addr), 0);

    // R11 reset contents
    peek_reg(0,  8'h05, "R11");
    peek_reg(17, 8'h7A, "R11");
    peek_reg(26, 8'hC7, "R11");
    peek_reg(27, 8'h00, "R11");
    peek_reg(30, 8'h5B, "R11");

    // R2 register region through Y=0x0011
    do_op(0, 1, 0, 0, 5, 0, "R2", 0);
    // R5 post-increment store into SRAM via X
    do_op(1, 0, 1, 0, 9, 0, "R5", 0);
    // R4 pre-decrement load returns the stored byte
    do_op(0, 0, 2, 0, 10, 0, "R4", 0);
    chk(load_data === m_rf[9], "R2", "SRAM round trip", int'(load_data), int'(m_rf[9]));
    // R9 direct I/O write, then R2 I/O region via Z=0x005B
    do_op(4, 0, 0, 0, 3, 59, "R9", 0);
    do_op(0, 2, 0, 0, 11, 0, "R2", 0);
    chk(load_data === m_rf[3], "R2", "I/O region alias", int'(load_data), int'(m_rf[3]));
    // R4 displacement: Y+10 = R27, move X out of the map
    do_op(1, 1, 3, 10, 3, 0, "R4", 0);
    do_op(1, 0, 0, 0, 4, 0, "R3", 0);
    do_op(0, 0, 0, 0, 12, 0, "R3", 0);
    chk(load_data === 8'h00, "R3", "unmapped load", int'(load_data), 0);
    do_op(1, 1, 3, 10, 31, 0, "R3", 0);
    do_op(0, 0, 0, 0, 13, 0, "R3", 0);
    chk(load_data === m_rf[9], "R3", "SRAM untouched by unmapped store", int'(load_data), int'(m_rf[9]));
    // R8 program reads from Z (odd, post-increment, even)
    do_op(2, 0, 0, 0, 14, 0, "R8", 0);
    do_op(2, 1, 1, 0, 15, 0, "R8", 0);
    do_op(2, 0, 2, 0, 16, 0, "R8", 0);
    // R7 intruding request during a load
    do_op(0, 0, 0, 0, 18, 0, "R7", 1);
    peek_reg(27, m_rf[27], "R7");
    // R10 load into low byte of the post-incremented pointer
    do_op(0, 0, 1, 0, 26, 0, "R10", 0);
    peek_reg(26, m_rf[26], "R10");
    peek_reg(27, m_rf[27], "R10");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op, rr;
      op = int'($urandom % 5);
      rr = (op == 0 || op == 2 || op == 3) ? int'($urandom % 26) : int'($urandom % 32);
      do_op(op, int'($urandom % 3), int'($urandom % 4), int'($urandom % 64), rr,
            int'($urandom % 63), "R4/R6", ($urandom % 8) == 0);
    end
    for (int i = 0; i < 32; i += 5) peek_reg(i, m_rf[i], "R10");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule